// File: doc/BRIEF.md
# Read-to-Write Turnaround Checker

This block watches the command stream of a DDR4-style memory controller and guards the gap between a READ and a later WRITE. Each READ loads a down-counter with the number of clocks the data bus needs to turn around. The count is the read latency plus half the burst, minus the write latency, plus a two-clock bus gap. One more clock is added when the 2-clock write preamble is on. A WRITE is legal again once the counter reaches zero. The rule does not depend on bank group, so the block takes no bank-group input.

The latencies come from configuration inputs: CAS latency, additive latency, CAS write latency, and the lowest legal CAS write latency for the speed bin. Two burst-mode bits select either a fixed burst of eight or per-command choice through the A12 address bit. A burst chopped to four still counts as eight when the gap is worked out. The block also checks the configuration and flags a write latency that is too low for the 2-clock preamble, as well as a reserved burst-mode code.

Top module: `r2w_turnaround`

## Requirements
- R1: While reset is asserted and right after it, gap_left is 0, wr_allow is 1, turn_viol is 0 and cfg_err is 0.
- R2: Let RL = CL + AL, WL = CWL + AL and N = RL + 4 − WL + 2. In the cycle after a READ, gap_left equals N − 1. It then falls by one per clock, so wr_allow rises exactly N cycles after the READ.
- R3: wr_allow is high in exactly those cycles where gap_left is 0, and gap_left stays at 0 while no READ arrives.
- R4: When cfg_wpre_2clk is 1, N grows by one clock.
- R5: With burst mode 2'b01 (per-command choice), A12 = 0 (chop to four) gives the same N as A12 = 1 (burst of eight). With burst mode 2'b00 (fixed eight), A12 has no effect on N.
- R6: The additive latency cancels out and has no effect on N.
- R7: A WRITE issued while gap_left is nonzero makes turn_viol 1 for the single following cycle. A WRITE issued while gap_left is 0 leaves turn_viol at 0.
- R8: A READ that arrives while the counter runs reloads it with the larger of the remaining count minus one and the new N − 1.
- R9: If the formula gives N below 1, N is taken as 1, so gap_left is 0 in the cycle after the READ.
- R10: One cycle after cfg_wpre_2clk is 1 while cfg_cwl ≤ cfg_cwl_floor, cfg_err is 1. With cfg_cwl ≥ cfg_cwl_floor + 1, the preamble raises no error.
- R11: One cycle after cfg_bl_mode is 2'b10 or 2'b11, cfg_err is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl | input | LAT_W | CAS latency in clocks |
| cfg_al | input | LAT_W | Additive latency in clocks |
| cfg_cwl | input | LAT_W | CAS write latency in clocks |
| cfg_cwl_floor | input | LAT_W | Lowest legal CAS write latency of the speed bin |
| cfg_bl_mode | input | 2 | Burst mode: 00 fixed eight, 01 chosen per command, others reserved |
| cfg_wpre_2clk | input | 1 | 1 selects the 2-clock write preamble |
| cmd_rd | input | 1 | READ command this cycle |
| cmd_wr | input | 1 | WRITE command this cycle |
| cmd_a12 | input | 1 | A12 bit of the command (1 = eight, 0 = chop to four) |
| wr_allow | output | 1 | A WRITE may issue this cycle |
| gap_left | output | LAT_W+2 | Clocks still to wait before a WRITE |
| turn_viol | output | 1 | A WRITE broke the turnaround in the previous cycle |
| cfg_err | output | 1 | Configuration was illegal in the previous cycle |

## Verification
The bench targets the boundary where the counter reaches zero and wr_allow must rise in exactly cycle N. A design that is off by one would open the bus a clock early or late. It also probes a chopped burst, which a design that halves the burst would shorten to a gap two clocks too small. It covers a latency set whose raw formula is negative, which a design without clamping would wrap into a huge wait. Back-to-back READs are checked so that a blind reload cannot shrink a pending wait. The write-latency floor is tested both at and just above its limit.

// File: rtl/r2w_pkg.sv
package r2w_pkg;

    typedef enum logic [1:0] {
        BLM_FIXED8 = 2'b00,
        BLM_PERCMD = 2'b01,
        BLM_RSVD_A = 2'b10,
        BLM_RSVD_B = 2'b11
    } bl_mode_e;

    localparam int unsigned BEATS_FULL = 8;
    localparam int unsigned BEATS_CHOP = 4;
    localparam int unsigned BUS_GAP    = 2;

endpackage

// File: rtl/r2w_burst_decode.sv
module r2w_burst_decode
    import r2w_pkg::*;
(
    input  logic [1:0] bl_mode,
    input  logic       a12,
    output logic [3:0] beats,
    output logic       mode_bad
);
    always_comb begin
        beats    = 4'(BEATS_FULL);
        mode_bad = 1'b0;
        unique case (bl_mode_e'(bl_mode))
            BLM_FIXED8: beats = 4'(BEATS_FULL);
            BLM_PERCMD: beats = a12 ? 4'(BEATS_FULL) : 4'(BEATS_CHOP);
            default:    mode_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/r2w_gap_calc.sv
module r2w_gap_calc
    import r2w_pkg::*;
#(
    parameter int LAT_W        = 6,
    parameter bit CHOP_AS_FULL = 1'b1,
    localparam int CNT_W       = LAT_W + 2,
    localparam int SW          = CNT_W + 2
) (
    input  logic [LAT_W-1:0] cl,
    input  logic [LAT_W-1:0] al,
    input  logic [LAT_W-1:0] cwl,
    input  logic             wpre_2clk,
    input  logic [3:0]       beats,
    output logic [CNT_W-1:0] load_val
);
    logic [3:0]          beats_eff;
    logic signed [SW-1:0] rl, wl, raw;

    generate
        if (CHOP_AS_FULL) begin : g_round_up
            assign beats_eff = (beats < 4'(BEATS_FULL)) ? 4'(BEATS_FULL) : beats;
        end else begin : g_as_is
            assign beats_eff = beats;
        end
    endgenerate

    always_comb begin
        rl  = SW'(cl) + SW'(al);
        wl  = SW'(cwl) + SW'(al);
        // value seen one cycle after the READ is N - 1
        raw = rl + SW'(beats_eff >> 1) - wl + SW'(BUS_GAP) + SW'(wpre_2clk) - SW'(1);
        if (raw < 0) load_val = '0;
        else         load_val = raw[CNT_W-1:0];
    end
endmodule

// File: rtl/r2w_cfg_check.sv
module r2w_cfg_check #(
    parameter int LAT_W = 6
) (
    input  logic [LAT_W-1:0] cwl,
    input  logic [LAT_W-1:0] cwl_floor,
    input  logic             wpre_2clk,
    input  logic             mode_bad,
    output logic             bad
);
    logic cwl_short;
    always_comb begin
        cwl_short = wpre_2clk && (cwl <= cwl_floor);
        bad       = cwl_short || mode_bad;
    end
endmodule

// File: rtl/r2w_turnaround.sv
module r2w_turnaround
    import r2w_pkg::*;
#(
    parameter int LAT_W        = 6,
    parameter bit CHOP_AS_FULL = 1'b1,
    localparam int CNT_W       = LAT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic [LAT_W-1:0] cfg_cwl,
    input  logic [LAT_W-1:0] cfg_cwl_floor,
    input  logic [1:0]       cfg_bl_mode,
    input  logic             cfg_wpre_2clk,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_a12,
    output logic             wr_allow,
    output logic [CNT_W-1:0] gap_left,
    output logic             turn_viol,
    output logic             cfg_err
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             viol;
        logic             err;
    } turn_state_t;

    turn_state_t st_d, st_q;

    logic [3:0]       beats;
    logic             mode_bad;
    logic             cfg_bad;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] dec_val;

    r2w_burst_decode u_burst (
        .bl_mode  (cfg_bl_mode),
        .a12      (cmd_a12),
        .beats    (beats),
        .mode_bad (mode_bad)
    );

    r2w_gap_calc #(.LAT_W(LAT_W), .CHOP_AS_FULL(CHOP_AS_FULL)) u_gap (
        .cl        (cfg_cl),
        .al        (cfg_al),
        .cwl       (cfg_cwl),
        .wpre_2clk (cfg_wpre_2clk),
        .beats     (beats),
        .load_val  (load_val)
    );

    r2w_cfg_check #(.LAT_W(LAT_W)) u_cfg (
        .cwl       (cfg_cwl),
        .cwl_floor (cfg_cwl_floor),
        .wpre_2clk (cfg_wpre_2clk),
        .mode_bad  (mode_bad),
        .bad       (cfg_bad)
    );

    always_comb begin
        st_d    = st_q;
        dec_val = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
        if (cmd_rd) st_d.cnt = (load_val > dec_val) ? load_val : dec_val;
        else        st_d.cnt = dec_val;
        st_d.viol = cmd_wr && (st_q.cnt != '0);
        st_d.err  = cfg_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gap_left  = st_q.cnt;
    assign wr_allow  = (st_q.cnt == '0);
    assign turn_viol = st_q.viol;
    assign cfg_err   = st_q.err;
endmodule

// File: rtl/r2w_turnaround_chk.sv
module r2w_turnaround_chk #(
    parameter int LAT_W  = 6,
    localparam int CNT_W = LAT_W + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_rd,
    input logic             cmd_wr,
    input logic [LAT_W-1:0] cfg_cwl,
    input logic [LAT_W-1:0] cfg_cwl_floor,
    input logic             cfg_wpre_2clk,
    input logic [1:0]       cfg_bl_mode,
    input logic             wr_allow,
    input logic [CNT_W-1:0] gap_left,
    input logic             turn_viol,
    input logic             cfg_err
);
    assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_left != '0 && !cmd_rd) |=> (gap_left == $past(gap_left) - CNT_W'(1)));

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_left == '0 && !cmd_rd) |=> (gap_left == '0 && wr_allow));

    assert_early_write_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && gap_left != '0) |=> turn_viol);

    assert_no_spurious_viol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> !turn_viol);

    assert_reload_no_shrink_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && gap_left != '0) |=> (gap_left >= $past(gap_left) - CNT_W'(1)));

    assert_cwl_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wpre_2clk && cfg_cwl <= cfg_cwl_floor) |=> cfg_err);

    assert_rsvd_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bl_mode[1] |=> cfg_err);
endmodule

bind r2w_turnaround r2w_turnaround_chk #(.LAT_W(LAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_rd        (cmd_rd),
    .cmd_wr        (cmd_wr),
    .cfg_cwl       (cfg_cwl),
    .cfg_cwl_floor (cfg_cwl_floor),
    .cfg_wpre_2clk (cfg_wpre_2clk),
    .cfg_bl_mode   (cfg_bl_mode),
    .wr_allow      (wr_allow),
    .gap_left      (gap_left),
    .turn_viol     (turn_viol),
    .cfg_err       (cfg_err)
);

// File: tb/r2w_turnaround_test.sv
`timescale 1ns/1ps
module r2w_turnaround_test;
    localparam int LAT_W = 6;
    localparam int CNT_W = LAT_W + 2;
    localparam int NV    = 6;
    // fields: cl, al, cwl, ctl{a12[3], wpre[2], mode[1:0]}, expected N
    localparam logic [39:0] VEC [NV] = '{
        40'h0B_00_09_08_08,
        40'h14_00_09_08_11,
        40'h0A_05_0A_08_06,
        40'h0E_00_0C_0C_09,
        40'h0C_02_0B_09_07,
        40'h10_01_08_05_0F
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LAT_W-1:0] cfg_cl = '0, cfg_al = '0, cfg_cwl = '0;
    logic [LAT_W-1:0] cfg_cwl_floor = LAT_W'(5);
    logic [1:0]       cfg_bl_mode = 2'b00;
    logic             cfg_wpre_2clk = 1'b0;
    logic             cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_a12 = 1'b1;
    logic             wr_allow, turn_viol, cfg_err;
    logic [CNT_W-1:0] gap_left;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    r2w_turnaround #(.LAT_W(LAT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_cwl(cfg_cwl),
        .cfg_cwl_floor(cfg_cwl_floor), .cfg_bl_mode(cfg_bl_mode), .cfg_wpre_2clk(cfg_wpre_2clk),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_a12(cmd_a12),
        .wr_allow(wr_allow), .gap_left(gap_left), .turn_viol(turn_viol), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int cl, input int al, input int cwl, input bit wpre,
                           input logic [1:0] mode, input bit a12);
        cfg_cl = LAT_W'(cl); cfg_al = LAT_W'(al); cfg_cwl = LAT_W'(cwl);
        cfg_wpre_2clk = wpre; cfg_bl_mode = mode; cmd_a12 = a12;
    endtask

    // READ, then check first gap value and the cycle wr_allow rises
    task automatic run_gap(input int cl, input int al, input int cwl, input bit wpre,
                           input logic [1:0] mode, input bit a12, input int n, input string req);
        int waited = 0;
        @(negedge clk);
        set_cfg(cl, al, cwl, wpre, mode, a12);
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        chk(int'(gap_left) == n - 1, req, int'(gap_left), n - 1);
        while (!wr_allow && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        chk(waited == n - 1, req, waited + 1, n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual %0d expected %0d cycles", 20000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_cfg(11, 0, 9, 1'b0, 2'b00, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(gap_left == '0, "R1", int'(gap_left), 0);
        chk(wr_allow == 1'b1, "R1", int'(wr_allow), 1);
        chk(turn_viol == 1'b0, "R1", int'(turn_viol), 0);
        chk(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_allow == 1'b1 && gap_left == '0, "R1", int'(gap_left), 0);

        for (int i = 0; i < NV; i++) begin
            run_gap(int'(VEC[i][39:32]), int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                    VEC[i][10], VEC[i][9:8], VEC[i][11], int'(VEC[i][7:0]), "R2");
        end

        // R3: idle counter stays at zero with wr_allow high
        repeat (3) @(negedge clk);
        chk(wr_allow && gap_left == '0, "R3", int'(gap_left), 0);

        run_gap(11, 0, 9, 1'b1, 2'b00, 1'b1, 9, "R4");
        run_gap(11, 0, 9, 1'b0, 2'b01, 1'b0, 8, "R5");
        run_gap(11, 0, 9, 1'b0, 2'b00, 1'b0, 8, "R5");
        run_gap(11, 7, 9, 1'b0, 2'b00, 1'b1, 8, "R6");
        run_gap(9, 0, 18, 1'b0, 2'b00, 1'b1, 1, "R9");

        // R7: early write flagged for one cycle
        @(negedge clk);
        set_cfg(11, 0, 9, 1'b0, 2'b00, 1'b1);
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(turn_viol == 1'b1, "R7", int'(turn_viol), 1);
        @(negedge clk);
        chk(turn_viol == 1'b0, "R7", int'(turn_viol), 0);
        while (!wr_allow) @(negedge clk);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(turn_viol == 1'b0, "R7", int'(turn_viol), 0);

        // R8: reload takes the larger value
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(int'(gap_left) == 5, "R8", int'(gap_left), 5);
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        chk(int'(gap_left) == 7, "R8", int'(gap_left), 7);
        set_cfg(9, 0, 18, 1'b0, 2'b00, 1'b1);
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        chk(int'(gap_left) == 6, "R8", int'(gap_left), 6);
        while (!wr_allow) @(negedge clk);

        // R10: write latency floor with 2-clock preamble
        set_cfg(11, 0, 5, 1'b1, 2'b00, 1'b1);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R10", int'(cfg_err), 1);
        cfg_cwl = LAT_W'(6);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R10", int'(cfg_err), 0);
        cfg_wpre_2clk = 1'b0;
        cfg_cwl = LAT_W'(5);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R10", int'(cfg_err), 0);

        // R11: reserved burst modes
        cfg_cwl = LAT_W'(9);
        cfg_bl_mode = 2'b10;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R11", int'(cfg_err), 1);
        cfg_bl_mode = 2'b11;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R11", int'(cfg_err), 1);
        cfg_bl_mode = 2'b01;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R11", int'(cfg_err), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule